// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the synchronous command front end of a NOR-style flash device. A bus decoder passes it one strobe per write cycle, with the write address and the low data byte. The block then chooses what a read returns: array data, the status register, the identifier codes or an erase-verify read at a latched address. It also drives one-cycle request pulses to an embedded program/erase engine, and updates its status flags when that engine reports completion.

Commands take one or two bus writes. Program and erase need a setup write first and then a confirming write. After a setup write, one or two FFh writes cancel the sequence without touching the engine. While the engine works the block accepts almost nothing: no commands at all during program, and only a suspend request during erase. While an erase is suspended, the command set shrinks to array read, status read and resume. Any sticky error flag locks the block into a small command set until software clears it.

Top module: `flash_cmd_fsm`

## Requirements
- R1: A synchronous low on `rst_n` returns the block to array mode (`rd_mode`=0) with `status`=80h and no request pulses. If reset arrives while a program, erase or suspended erase is pending, `eng_abort` is high for one cycle.
- R2: Writing FFh in the idle state selects array mode (`rd_mode`=0). The mode then stays unchanged until another accepted command is written.
- R3: Writing 10h or 40h, followed by any write other than FFh, gives one `eng_start` pulse with `eng_op`=0 and that write's address and data. It also selects status mode (`rd_mode`=1) and drops `status[7]` (ready) to 0.
- R4: An erase setup followed by its matching confirm starts the engine with one `eng_op`. The pairs are: 20h/20h gives op 1 (chip), 60h/60h gives op 2 (block, address passed), 30h/30h gives op 3 (auto chip) and 20h/D0h gives op 4 (auto block, address passed).
- R5: After an erase setup, a write that is neither the matching confirm nor FFh sets `status[5]` (erase fail) and `status[4]` (program fail), selects status mode and starts nothing.
- R6: 90h selects identifier mode (`rd_mode`=2). There `rd_data` is 00C2h when `rd_a0`=0 and 002Bh when `rd_a0`=1.
- R7: A0h selects verify mode (`rd_mode`=3) and loads that write's address into `verify_addr`.
- R8: 70h selects status mode, where `rd_data` = {00h, `status`}. 50h clears the sticky bits `status[5:3]`.
- R9: While a program is running, every write is ignored: mode, status and request outputs do not change.
- R10: While an erase is running, only B0h has an effect. It gives one `eng_suspend` pulse, sets `status[6]` (suspended) and sets `status[7]` to 1.
- R11: While suspended, only FFh (array mode), 70h (status mode) and D0h are accepted. D0h gives one `eng_resume` pulse and clears `status[6]` and `status[7]`. D0h has no effect in any other state.
- R12: After a program setup, one FFh returns to array mode. After an erase setup, two FFh writes in a row do the same. Neither case starts the engine or sets a status bit.
- R13: While any of `status[5:3]` is set, only 50h, 70h and FFh are accepted in the idle state.
- R14: `eng_done` ends a running operation and sets `status[7]`. If `eng_fail` or `eng_vpp_low` is high, it sets `status[4]` for a program or `status[5]` for an erase. `eng_vpp_low` also sets `status[3]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset / power-down |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data byte (command code or program data) |
| rd_a0 | input | 1 | Read address bit 0, selects identifier code |
| eng_done | input | 1 | Engine finished the running operation |
| eng_fail | input | 1 | Engine operation failed, sampled with eng_done |
| eng_vpp_low | input | 1 | Supply was out of range, sampled with eng_done |
| rd_mode | output | 2 | 0 array, 1 status, 2 identifier, 3 verify |
| rd_data | output | 16 | Status or identifier word for non-array reads |
| status | output | 8 | Status register: 7 ready, 6 suspended, 5 erase fail, 4 program fail, 3 supply low |
| verify_addr | output | AW | Address latched by the verify command |
| eng_start | output | 1 | One-cycle start request |
| eng_op | output | 3 | Operation code for eng_start |
| eng_addr | output | AW | Operation address |
| eng_data | output | 8 | Program data |
| eng_abort | output | 1 | Abort request issued by reset |
| eng_suspend | output | 1 | One-cycle suspend request |
| eng_resume | output | 1 | One-cycle resume request |

## Verification
The assertions assume that `eng_done` comes only while an operation is running and not suspended, and that `wr_en` is a single-cycle strobe. The bench keeps to this. It raises `eng_done` only after it has seen the start or resume pulse, and it drops `wr_en` for at least one cycle between writes. The bench sweeps all 256 data values after an erase setup, during a running program, during a running erase, while suspended and under error lockout. For each value it computes the expected mode, status and pulses from the command code.

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm #(
  parameter int         AW       = 17,
  parameter logic [7:0] MFR_CODE = 8'hC2,
  parameter logic [7:0] DEV_CODE = 8'h2B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          rd_a0,
  input  logic          eng_done,
  input  logic          eng_fail,
  input  logic          eng_vpp_low,
  output logic [1:0]    rd_mode,
  output logic [15:0]   rd_data,
  output logic [7:0]    status,
  output logic [AW-1:0] verify_addr,
  output logic          eng_start,
  output logic [2:0]    eng_op,
  output logic [AW-1:0] eng_addr,
  output logic [7:0]    eng_data,
  output logic          eng_abort,
  output logic          eng_suspend,
  output logic          eng_resume
);
  localparam logic [2:0] S_IDLE = 3'd0, S_PSET = 3'd1, S_ESET = 3'd2, S_EFF = 3'd3,
                         S_PBUSY = 3'd4, S_EBUSY = 3'd5, S_ESUSP = 3'd6;
  localparam logic [1:0] M_ARR = 2'd0, M_STAT = 2'd1, M_ID = 2'd2, M_VER = 2'd3;

  logic [2:0] st;
  logic [2:0] err;
  logic [7:0] ecode;
  logic       cfm_ok;
  logic [2:0] cfm_op;
  logic       busy;

  assign busy = (st == S_PBUSY) || (st == S_EBUSY);
  assign status = {~busy, st == S_ESUSP, err, 3'b000};
  assign rd_data = (rd_mode == M_STAT) ? {8'h00, status} :
                   (rd_mode == M_ID)   ? {8'h00, rd_a0 ? DEV_CODE : MFR_CODE} : 16'h0000;

  always_comb begin
    cfm_ok = 1'b1;
    cfm_op = 3'd0;
    if      (ecode == 8'h20 && wr_data == 8'h20) cfm_op = 3'd1;
    else if (ecode == 8'h60 && wr_data == 8'h60) cfm_op = 3'd2;
    else if (ecode == 8'h30 && wr_data == 8'h30) cfm_op = 3'd3;
    else if (ecode == 8'h20 && wr_data == 8'hD0) cfm_op = 3'd4;
    else cfm_ok = 1'b0;
  end

  always_ff @(posedge clk) begin
    eng_start   <= 1'b0;
    eng_suspend <= 1'b0;
    eng_resume  <= 1'b0;
    eng_abort   <= 1'b0;
    if (!rst_n) begin
      eng_abort   <= busy || (st == S_ESUSP);
      st          <= S_IDLE;
      rd_mode     <= M_ARR;
      err         <= 3'b000;
      ecode       <= 8'h00;
      verify_addr <= '0;
      eng_op      <= 3'd0;
      eng_addr    <= '0;
      eng_data    <= 8'h00;
    end else begin
      case (st)
        S_IDLE: if (wr_en) begin
          case (wr_data)
            8'hFF: rd_mode <= M_ARR;
            8'h70: rd_mode <= M_STAT;
            8'h50: err <= 3'b000;
            default: if (err == 3'b000) begin
              case (wr_data)
                8'h90: rd_mode <= M_ID;
                8'hA0: begin rd_mode <= M_VER; verify_addr <= wr_addr; end
                8'h10, 8'h40: st <= S_PSET;
                8'h20, 8'h30, 8'h60: begin st <= S_ESET; ecode <= wr_data; end
                default: ;
              endcase
            end
          endcase
        end
        S_PSET: if (wr_en) begin
          if (wr_data == 8'hFF) begin
            st <= S_IDLE; rd_mode <= M_ARR;
          end else begin
            st <= S_PBUSY; rd_mode <= M_STAT;
            eng_start <= 1'b1; eng_op <= 3'd0;
            eng_addr <= wr_addr; eng_data <= wr_data;
          end
        end
        S_ESET, S_EFF: if (wr_en) begin
          if (wr_data == 8'hFF && st == S_ESET) begin
            st <= S_EFF;
          end else if (wr_data == 8'hFF) begin
            st <= S_IDLE; rd_mode <= M_ARR;
          end else if (cfm_ok && st == S_ESET) begin
            st <= S_EBUSY; rd_mode <= M_STAT;
            eng_start <= 1'b1; eng_op <= cfm_op; eng_addr <= wr_addr;
          end else begin
            st <= S_IDLE; rd_mode <= M_STAT; err[2:1] <= 2'b11;
          end
        end
        S_PBUSY: if (eng_done) begin
          st <= S_IDLE;
          err[1] <= err[1] | eng_fail | eng_vpp_low;
          err[0] <= err[0] | eng_vpp_low;
        end
        S_EBUSY: if (eng_done) begin
          st <= S_IDLE;
          err[2] <= err[2] | eng_fail | eng_vpp_low;
          err[0] <= err[0] | eng_vpp_low;
        end else if (wr_en && wr_data == 8'hB0) begin
          st <= S_ESUSP; rd_mode <= M_STAT; eng_suspend <= 1'b1;
        end
        S_ESUSP: if (wr_en) begin
          case (wr_data)
            8'hFF: rd_mode <= M_ARR;
            8'h70: rd_mode <= M_STAT;
            8'hD0: begin st <= S_EBUSY; rd_mode <= M_STAT; eng_resume <= 1'b1; end
            default: ;
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_fsm_chk.sv
module flash_cmd_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] status,
  input logic [1:0] rd_mode,
  input logic       eng_start,
  input logic       eng_suspend,
  input logic       eng_resume
);
  a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !status[7] && rd_mode == 2'd1);
  a_r9_busy_status_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !status[7] |-> rd_mode == 2'd1);
  a_r10_suspend_flag: assert property (@(posedge clk) disable iff (!rst_n)
    eng_suspend |-> status[6] && status[7]);
  a_r10_suspend_ready: assert property (@(posedge clk) disable iff (!rst_n)
    status[6] |-> status[7]);
  a_r11_resume_clears: assert property (@(posedge clk) disable iff (!rst_n)
    eng_resume |-> !status[6] && !status[7]);
  a_r12_ff_never_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == 8'hFF) |=> !eng_start);
  a_r11_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eng_start, eng_suspend, eng_resume}));
endmodule

bind flash_cmd_fsm flash_cmd_fsm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .status(status),
  .rd_mode(rd_mode), .eng_start(eng_start), .eng_suspend(eng_suspend),
  .eng_resume(eng_resume)
);

// File: tb/sim_flash_cmd_fsm.sv
`timescale 1ns/100ps
module sim_flash_cmd_fsm;
  localparam int AW = 17;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_a0 = 1'b0;
  logic eng_done = 1'b0, eng_fail = 1'b0, eng_vpp_low = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] rd_mode;
  logic [15:0] rd_data;
  logic [7:0] status, eng_data;
  logic [AW-1:0] verify_addr, eng_addr;
  logic eng_start, eng_abort, eng_suspend, eng_resume;
  logic [2:0] eng_op;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_cmd_fsm #(.AW(AW)) u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic done(input logic f, input logic v);
    @(negedge clk); eng_done = 1'b1; eng_fail = f; eng_vpp_low = v;
    @(negedge clk); eng_done = 1'b0; eng_fail = 1'b0; eng_vpp_low = 1'b0;
  endtask

  function automatic logic [2:0] pulses();
    return {eng_start, eng_suspend, eng_resume};
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset mode", rd_mode, 0);
    chk("R1 reset status", status, 8'h80);
    chk("R1 reset pulses", {pulses(), eng_abort}, 0);

    wr(0, 8'h70);
    chk("R8 status mode", rd_mode, 1);
    chk("R8 status word", rd_data, 16'h0080);
    wr(0, 8'hFF);
    chk("R2 array mode", rd_mode, 0);
    repeat (5) @(negedge clk);
    chk("R2 mode held", rd_mode, 0);

    wr(0, 8'h90);
    rd_a0 = 1'b0; #0.5;
    chk("R6 mfr code", {rd_mode, rd_data}, {2'd2, 16'h00C2});
    rd_a0 = 1'b1; #0.5;
    chk("R6 dev code", rd_data, 16'h002B);
    rd_a0 = 1'b0;

    wr(17'h1234, 8'hA0);
    chk("R7 verify mode", rd_mode, 3);
    chk("R7 verify addr", verify_addr, 17'h1234);
    wr(17'h00F0, 8'hA0);
    chk("R7 verify addr reload", verify_addr, 17'h00F0);

    // program sweep over setup code and data
    for (int d = 0; d < 255; d += 17) begin
      wr(0, (d & 1) ? 8'h40 : 8'h10);
      wr(AW'(d * 3), 8'(d));
      chk("R3 start", {pulses(), eng_op}, {3'b100, 3'd0});
      chk("R3 addr/data", {eng_addr, eng_data}, {AW'(d * 3), 8'(d)});
      chk("R3 busy status", {rd_mode, status}, {2'd1, 8'h00});
      done(1'b0, 1'b0);
      chk("R14 program ok", status, 8'h80);
    end

    // erase confirm sweep after 20h setup
    for (int d = 0; d < 256; d++) begin
      wr(17'h1F000, 8'h20);
      wr(17'h1F000, 8'(d));
      if (d == 8'h20 || d == 8'hD0) begin
        chk("R4 erase start", {pulses(), eng_op}, {3'b100, (d == 8'h20) ? 3'd1 : 3'd4});
        chk("R4 erase addr", eng_addr, 17'h1F000);
        done(1'b0, 1'b0);
        chk("R14 erase ok", status, 8'h80);
      end else if (d == 8'hFF) begin
        chk("R12 first FF no start", {pulses(), status}, {3'b000, 8'h80});
        wr(0, 8'hFF);
        chk("R12 erase abort", {pulses(), rd_mode, status}, {3'b000, 2'd0, 8'h80});
      end else begin
        chk("R5 wrong confirm", {pulses(), rd_mode, status}, {3'b000, 2'd1, 8'hB0});
        wr(0, 8'h50);
        chk("R8 clear", status, 8'h80);
      end
    end

    wr(0, 8'h60); wr(17'h04000, 8'h60);
    chk("R4 block erase", {eng_start, eng_op, eng_addr}, {1'b1, 3'd2, 17'h04000});
    done(1'b1, 1'b0);
    chk("R14 erase fail", status, 8'hA0);
    wr(0, 8'h50);
    wr(0, 8'h30); wr(0, 8'h30);
    chk("R4 auto chip", {eng_start, eng_op}, {1'b1, 3'd3});
    done(1'b0, 1'b0);
    wr(0, 8'h30); wr(0, 8'hFF); wr(0, 8'h30);
    chk("R5 non-FF after one FF", {pulses(), status}, {3'b000, 8'hB0});
    wr(0, 8'h50);

    wr(0, 8'h10); wr(0, 8'hFF);
    chk("R12 program abort", {pulses(), rd_mode, status}, {3'b000, 2'd0, 8'h80});

    // program busy: every code ignored
    wr(0, 8'h40); wr(5, 8'h3C);
    for (int d = 0; d < 256; d++) begin
      wr(0, 8'(d));
      chk("R9 program ignores", {pulses(), rd_mode, status}, {3'b000, 2'd1, 8'h00});
    end
    done(1'b1, 1'b0);
    chk("R14 program fail", status, 8'h90);

    // error lockout
    for (int d = 0; d < 256; d++) begin
      if (d == 8'h50 || d == 8'h70 || d == 8'hFF) continue;
      wr(0, 8'(d));
      chk("R13 lockout", {pulses(), rd_mode, status}, {3'b000, 2'd1, 8'h90});
    end
    wr(0, 8'hFF);
    chk("R13 FF accepted", rd_mode, 0);
    wr(0, 8'h70);
    chk("R13 70 accepted", rd_mode, 1);
    wr(0, 8'h50);
    chk("R13 50 clears", status, 8'h80);
    wr(0, 8'h10); wr(0, 8'h01); done(1'b0, 1'b1);
    chk("R14 supply low", status, 8'h98);
    wr(0, 8'h50);

    wr(0, 8'hD0);
    chk("R11 D0 idle no effect", {pulses(), rd_mode, status}, {3'b000, 2'd1, 8'h80});

    // erase busy / suspend
    wr(0, 8'h20); wr(0, 8'h20);
    for (int d = 0; d < 256; d++) begin
      if (d == 8'hB0) continue;
      wr(0, 8'(d));
      chk("R10 erase ignores", {pulses(), rd_mode, status}, {3'b000, 2'd1, 8'h00});
    end
    wr(0, 8'hB0);
    chk("R10 suspend", {pulses(), status}, {3'b010, 8'hC0});
    for (int d = 0; d < 256; d++) begin
      if (d == 8'hFF || d == 8'h70 || d == 8'hD0) continue;
      wr(0, 8'(d));
      chk("R11 suspend ignores", {pulses(), rd_mode, status}, {3'b000, 2'd1, 8'hC0});
    end
    wr(0, 8'hFF);
    chk("R11 FF in suspend", {rd_mode, status}, {2'd0, 8'hC0});
    wr(0, 8'h70);
    chk("R11 70 in suspend", rd_mode, 1);
    wr(0, 8'hD0);
    chk("R11 resume", {pulses(), status}, {3'b001, 8'h00});
    done(1'b0, 1'b0);
    chk("R14 done after resume", status, 8'h80);

    // reset while busy
    wr(0, 8'h10); wr(9, 8'h55);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 abort pulse", eng_abort, 1);
    @(negedge clk);
    chk("R1 abort single", eng_abort, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {rd_mode, status}, {2'd0, 8'h80});

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule